// File: doc/BRIEF.md
# Frame syndrome classifier and corrector

This block sits behind a configuration-frame readback path. The frame's words are written into an internal buffer through a load port as they arrive. Afterwards the 12-bit error syndrome computed over that frame is presented with a valid strobe. The block sorts the syndrome into one of four outcomes: clean frame, single data-bit error, error confined to the final parity bit, or uncorrectable error. It reports the outcome with a one-cycle status strobe.

For a single data-bit error the block repairs the buffered copy in place. It reads the buffer word that holds the faulty bit, inverts that bit and writes the word back. It then pulses `done_o` together with a rewrite request, so that a downstream engine can push the repaired frame back. A parity-only error changes no data word, but it still raises the rewrite request so that the stored check bits get refreshed. An uncorrectable result leaves the buffer untouched and only reports the status. A second read port lets the rewrite engine, or a bench, fetch any buffer word.

Top module: `frame_scrub_fix`

## Requirements
- R1: After reset, `stat_valid_o`, `busy_o`, `done_o` and `rewrite_o` are all 0.
- R2: A syndrome of all zeros gives status 2'b00 (clean), with `stat_valid_o` high for one cycle after the accepting edge. It produces no `done_o`, no `rewrite_o` and no buffer change.
- R3: If syndrome bit 11 is 0 and location L = bits 10..0 lies in 1..1311, the status is 2'b01 (single). Bit L mod 32 of buffer word L/32 is inverted, and every other bit of the buffer is unchanged.
- R4: After a single-error syndrome is accepted, `busy_o` is high in the two following cycles. `done_o` and `rewrite_o` are then high together for exactly one cycle, in the third cycle after the accepting edge, with `busy_o` low.
- R5: Syndrome 12'h800 (bit 11 set, location zero) gives status 2'b10 (parity only). `rewrite_o` is high in the same cycle as `stat_valid_o`, with no `done_o` and no buffer change.
- R6: If bit 11 is 1 and bits 10..0 are non-zero, the status is 2'b11 (uncorrectable). There is no buffer write, no `rewrite_o` and no `done_o`.
- R7: If bit 11 is 0 and the location is 1312 or above, the status is also 2'b11, and the buffer is unchanged.
- R8: A syndrome strobe that arrives while `busy_o` is high is ignored. It produces no status strobe and no buffer change.
- R9: While idle, a load with `ld_we` high writes `ld_data` to word `ld_addr`. Read port data `rd_data_o` shows word `rd_addr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Buffer load strobe (honoured only while idle) |
| ld_addr | input | 6 | Buffer word index for loads |
| ld_data | input | 32 | Buffer load data |
| rd_addr | input | 6 | Read port word index |
| rd_data_o | output | 32 | Read port data, one cycle latency |
| syn_valid | input | 1 | Syndrome strobe |
| syn | input | 12 | Syndrome: bit 11 is the double flag, bits 10..0 the location |
| stat_valid_o | output | 1 | One-cycle status strobe |
| stat_o | output | 2 | 00 clean, 01 single, 10 parity only, 11 uncorrectable |
| busy_o | output | 1 | Correction in progress |
| done_o | output | 1 | One-cycle pulse when a correction is written back |
| rewrite_o | output | 1 | One-cycle request to push the frame back |

## Verification
The assertions take for granted that `syn_valid` and `syn` are known after reset. They also take for granted that the buffer has been filled through the load port before a syndrome refers to it; an unloaded word reads as unknown. The bench loads all 41 words with a known pattern first and keeps a model copy of the buffer. It drives loads only while `busy_o` is low. It raises the syndrome strobe during a correction only in the scenario that checks R8, and drops the strobe before the block returns to idle.

// File: rtl/frame_scrub_pkg.sv
package frame_scrub_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN  = 2'b00,
    ST_SINGLE = 2'b01,
    ST_PARITY = 2'b10,
    ST_UNCORR = 2'b11
  } fix_status_e;
endpackage

// File: rtl/frame_syn_decode.sv
module frame_syn_decode
  import frame_scrub_pkg::*;
#(
  parameter int SYNW  = 12,
  parameter int WORDS = 41,
  parameter int WBITS = 32,
  parameter int AW    = 6,
  parameter int BW    = 5
) (
  input  logic [SYNW-1:0] syn,
  output fix_status_e     cls,
  output logic [AW-1:0]   wrd,
  output logic [BW-1:0]   bitx
);
  localparam int LOCW       = SYNW - 1;
  localparam int FRAME_BITS = WORDS * WBITS;
  localparam logic [LOCW-1:0] LIMIT = LOCW'(FRAME_BITS);

  logic [LOCW-1:0] loc;
  logic            dbl;

  assign loc  = syn[LOCW-1:0];
  assign dbl  = syn[LOCW];
  assign wrd  = AW'(loc >> BW);
  assign bitx = loc[BW-1:0];

  always_comb begin
    if (!dbl && loc == '0)     cls = ST_CLEAN;
    else if (dbl && loc == '0) cls = ST_PARITY;
    else if (dbl)              cls = ST_UNCORR;
    else if (loc >= LIMIT)     cls = ST_UNCORR;
    else                       cls = ST_SINGLE;
  end

  // R7: a correctable location always maps inside the frame buffer
  always_comb begin
    if (cls == ST_SINGLE) begin
      a_wrd_range_r7: assert (int'(wrd) < WORDS);
    end
  end
endmodule

// File: rtl/frame_buf_ram.sv
module frame_buf_ram #(
  parameter int WBITS = 32,
  parameter int WORDS = 41,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             a_we,
  input  logic [AW-1:0]    a_addr,
  input  logic [WBITS-1:0] a_wdata,
  output logic [WBITS-1:0] a_rdata,
  input  logic [AW-1:0]    b_addr,
  output logic [WBITS-1:0] b_rdata
);
  logic [WBITS-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/frame_fix_ctrl.sv
module frame_fix_ctrl
  import frame_scrub_pkg::*;
#(
  parameter int WBITS = 32,
  parameter int AW    = 6,
  parameter int BW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             syn_valid,
  input  fix_status_e      cls,
  input  logic [AW-1:0]    wrd,
  input  logic [BW-1:0]    bitx,
  input  logic [WBITS-1:0] mem_rdata,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [WBITS-1:0] mem_wdata,
  output logic             stat_valid_o,
  output fix_status_e      stat_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             rewrite_o
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} fix_state_e;

  fix_state_e       state;
  logic [AW-1:0]    wrd_q;
  logic [BW-1:0]    bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      wrd_q        <= '0;
      bit_q        <= '0;
      stat_valid_o <= 1'b0;
      stat_o       <= ST_CLEAN;
      done_o       <= 1'b0;
      rewrite_o    <= 1'b0;
    end else begin
      stat_valid_o <= 1'b0;
      done_o       <= 1'b0;
      rewrite_o    <= 1'b0;
      case (state)
        S_IDLE: begin
          if (syn_valid) begin
            stat_o       <= cls;
            stat_valid_o <= 1'b1;
            if (cls == ST_PARITY) rewrite_o <= 1'b1;
            if (cls == ST_SINGLE) begin
              wrd_q <= wrd;
              bit_q <= bitx;
              state <= S_RD;
            end
          end
        end
        S_RD: state <= S_WR;
        S_WR: begin
          state     <= S_IDLE;
          done_o    <= 1'b1;
          rewrite_o <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy_o    = (state != S_IDLE);
  assign mem_we    = (state == S_WR);
  assign mem_addr  = wrd_q;
  assign mem_wdata = mem_rdata ^ (WBITS'(1) << bit_q);

  // R4: done is a single-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R4: leaving busy always coincides with done and rewrite
  p_busy_end_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (done_o && rewrite_o));
  // R4: busy lasts at least two cycles
  p_busy_len_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |=> busy_o);
  // R3: a single-error status starts a correction
  p_single_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (stat_valid_o && stat_o == ST_SINGLE) |-> busy_o);
  // R5: parity-only asks for a rewrite without a correction
  p_parity_rewr_r5: assert property (@(posedge clk) disable iff (rst)
    (stat_valid_o && stat_o == ST_PARITY) |-> (rewrite_o && !busy_o && !done_o));
  // R6: uncorrectable results start nothing
  p_uncorr_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (stat_valid_o && stat_o == ST_UNCORR) |-> (!rewrite_o && !busy_o && !done_o));
  // R8: a strobe seen while busy produces no status
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && syn_valid) |=> !stat_valid_o);
endmodule

// File: rtl/frame_scrub_fix.sv
module frame_scrub_fix
  import frame_scrub_pkg::*;
#(
  parameter int SYNW  = 12,
  parameter int WORDS = 41,
  parameter int WBITS = 32,
  localparam int AW   = $clog2(WORDS),
  localparam int BW   = $clog2(WBITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_we,
  input  logic [AW-1:0]    ld_addr,
  input  logic [WBITS-1:0] ld_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WBITS-1:0] rd_data_o,
  input  logic             syn_valid,
  input  logic [SYNW-1:0]  syn,
  output logic             stat_valid_o,
  output logic [1:0]       stat_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             rewrite_o
);
  fix_status_e       cls;
  fix_status_e       stat_q;
  logic [AW-1:0]     wrd;
  logic [BW-1:0]     bitx;
  logic              fix_we;
  logic [AW-1:0]     fix_addr;
  logic [WBITS-1:0]  fix_wdata;
  logic              a_we;
  logic [AW-1:0]     a_addr;
  logic [WBITS-1:0]  a_wdata;
  logic [WBITS-1:0]  a_rdata;

  frame_syn_decode #(.SYNW(SYNW), .WORDS(WORDS), .WBITS(WBITS), .AW(AW), .BW(BW)) dec_i (
    .syn(syn), .cls(cls), .wrd(wrd), .bitx(bitx)
  );

  frame_fix_ctrl #(.WBITS(WBITS), .AW(AW), .BW(BW)) ctrl_i (
    .clk(clk), .rst(rst), .syn_valid(syn_valid), .cls(cls), .wrd(wrd), .bitx(bitx),
    .mem_rdata(a_rdata), .mem_we(fix_we), .mem_addr(fix_addr), .mem_wdata(fix_wdata),
    .stat_valid_o(stat_valid_o), .stat_o(stat_q), .busy_o(busy_o),
    .done_o(done_o), .rewrite_o(rewrite_o)
  );

  // port A belongs to the corrector while busy, to the loader otherwise
  always_comb begin
    if (busy_o) begin
      a_we    = fix_we;
      a_addr  = fix_addr;
      a_wdata = fix_wdata;
    end else begin
      a_we    = ld_we;
      a_addr  = ld_addr;
      a_wdata = ld_data;
    end
  end

  frame_buf_ram #(.WBITS(WBITS), .WORDS(WORDS), .AW(AW)) ram_i (
    .clk(clk), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_addr(rd_addr), .b_rdata(rd_data_o)
  );

  assign stat_o = stat_q;
endmodule

// File: tb/frame_scrub_fix_tb_top.sv
module frame_scrub_fix_tb_top;
  localparam int WORDS = 41;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_we = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rd_data_o;
  logic        syn_valid = 1'b0;
  logic [11:0] syn = '0;
  logic        stat_valid_o;
  logic [1:0]  stat_o;
  logic        busy_o, done_o, rewrite_o;

  int checks = 0;
  int errs   = 0;
  bit finished = 1'b0;
  logic [31:0] model [WORDS];

  always #4 clk = ~clk;

  frame_scrub_fix dut_i (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(rd_addr), .rd_data_o(rd_data_o), .syn_valid(syn_valid), .syn(syn),
    .stat_valid_o(stat_valid_o), .stat_o(stat_o), .busy_o(busy_o),
    .done_o(done_o), .rewrite_o(rewrite_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_word(input int a, output logic [31:0] v);
    @(negedge clk) rd_addr = 6'(a);
    @(negedge clk) v = rd_data_o;
  endtask

  task automatic compare_all(input string tag);
    logic [31:0] v;
    for (int i = 0; i < WORDS; i++) begin
      read_word(i, v);
      chk(tag, v, model[i]);
    end
  endtask

  // drive one syndrome; returns at the negedge right after the accepting edge
  task automatic send_syn(input logic [11:0] s);
    @(negedge clk);
    syn = s; syn_valid = 1'b1;
    @(negedge clk);
    syn_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 stat_valid", {31'b0, stat_valid_o}, 32'd0);
    chk("R1 busy", {31'b0, busy_o}, 32'd0);
    chk("R1 done", {31'b0, done_o}, 32'd0);
    chk("R1 rewrite", {31'b0, rewrite_o}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_load();
    logic [31:0] v;
    for (int i = 0; i < WORDS; i++) begin
      @(negedge clk);
      model[i] = 32'h5A3C_96E1 ^ (32'(i) * 32'h0101_0101);
      ld_we = 1'b1; ld_addr = 6'(i); ld_data = model[i];
    end
    @(negedge clk) ld_we = 1'b0;
    read_word(7, v);
    chk("R9 load readback", v, model[7]);
    compare_all("R9 full frame");
  endtask

  task automatic t_single(input int loc);
    send_syn(12'(loc));
    chk("R3 stat_valid", {31'b0, stat_valid_o}, 32'd1);
    chk("R3 status", {30'b0, stat_o}, 32'd1);
    chk("R4 busy c1", {31'b0, busy_o}, 32'd1);
    @(negedge clk);
    chk("R4 busy c2", {31'b0, busy_o}, 32'd1);
    chk("R4 no early done", {31'b0, done_o}, 32'd0);
    @(negedge clk);
    chk("R4 done", {31'b0, done_o}, 32'd1);
    chk("R4 rewrite", {31'b0, rewrite_o}, 32'd1);
    chk("R4 busy released", {31'b0, busy_o}, 32'd0);
    @(negedge clk);
    chk("R4 done one cycle", {31'b0, done_o}, 32'd0);
    model[loc / 32][loc % 32] = ~model[loc / 32][loc % 32];
    compare_all($sformatf("R3 frame after loc %0d", loc));
  endtask

  task automatic t_clean();
    send_syn(12'h000);
    chk("R2 stat_valid", {31'b0, stat_valid_o}, 32'd1);
    chk("R2 status", {30'b0, stat_o}, 32'd0);
    chk("R2 rewrite", {31'b0, rewrite_o}, 32'd0);
    chk("R2 busy", {31'b0, busy_o}, 32'd0);
    @(negedge clk);
    chk("R2 stat_valid one cycle", {31'b0, stat_valid_o}, 32'd0);
    chk("R2 no done", {31'b0, done_o}, 32'd0);
    compare_all("R2 frame");
  endtask

  task automatic t_parity();
    send_syn(12'h800);
    chk("R5 status", {30'b0, stat_o}, 32'd2);
    chk("R5 rewrite", {31'b0, rewrite_o}, 32'd1);
    chk("R5 busy", {31'b0, busy_o}, 32'd0);
    @(negedge clk);
    chk("R5 no done", {31'b0, done_o}, 32'd0);
    chk("R5 rewrite one cycle", {31'b0, rewrite_o}, 32'd0);
    compare_all("R5 frame");
  endtask

  task automatic t_uncorr(input logic [11:0] s, input string tag);
    send_syn(s);
    chk({tag, " status"}, {30'b0, stat_o}, 32'd3);
    chk({tag, " rewrite"}, {31'b0, rewrite_o}, 32'd0);
    chk({tag, " busy"}, {31'b0, busy_o}, 32'd0);
    @(negedge clk);
    chk({tag, " no done"}, {31'b0, done_o}, 32'd0);
    compare_all({tag, " frame"});
  endtask

  task automatic t_busy_ignore();
    send_syn(12'd100);
    chk("R8 first accepted", {31'b0, stat_valid_o}, 32'd1);
    syn = 12'd200; syn_valid = 1'b1;
    @(negedge clk);
    chk("R8 no status c2", {31'b0, stat_valid_o}, 32'd0);
    @(negedge clk);
    syn_valid = 1'b0;
    chk("R8 no status c3", {31'b0, stat_valid_o}, 32'd0);
    chk("R8 done", {31'b0, done_o}, 32'd1);
    @(negedge clk);
    chk("R8 still no status", {31'b0, stat_valid_o}, 32'd0);
    model[100 / 32][100 % 32] = ~model[100 / 32][100 % 32];
    compare_all("R8 frame");
  endtask

  initial begin
    t_reset();
    t_load();
    t_clean();
    t_single(1);
    t_single(31);
    t_single(32);
    t_single(700);
    t_single(1311);
    t_parity();
    t_uncorr(12'h805, "R6 double");
    t_uncorr(12'hFFF, "R6 double max");
    t_uncorr(12'd1312, "R7 loc 1312");
    t_uncorr(12'h7FF, "R7 loc 2047");
    t_busy_ignore();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end
endmodule